// File: doc/BRIEF.md
# Strobe Phase-Width Statistics Monitor

This block watches one asynchronous strobe from the fast clock domain. It measures how long each high phase and each low phase lasts, in fast-clock cycles. For each phase polarity it keeps the shortest and the longest width seen so far. Take a strobe whose period is about thirteen fast cycles. A clean strobe shows widths that differ from the nominal by at most one cycle, because the sampling is asynchronous. A width of one or two cycles points to edge bounce or a doubled clock edge. A width well above nominal points to a dropped pulse.

The raw input first passes through a flip-flop synchronizer. A small state machine then follows the synchronized level. It throws away the phase that is already in progress after reset or after a clear. After that it counts each phase and hands the finished width to two extreme trackers, one for high phases and one for low phases. Two sticky flags record whether any finished phase was suspiciously short or suspiciously long. A one-cycle clear strobe restarts the whole collection.

Top module: `pwstat_monitor`

## Requirements
- R1: After reset, both minimum outputs read all ones (255 at the default width of 8), both maximum outputs read 0, and both flags read 0.
- R2: The input goes through SYNC_STAGES flip-flops (default 2). A finished phase is reflected on the outputs SYNC_STAGES+1 rising clock edges after the first edge that samples the input level ending it (3 at the default).
- R3: A high phase lasting N clock cycles at the input is committed as width N when the input falls. `min_high` becomes the smaller of itself and N, and `max_high` becomes the larger of itself and N.
- R4: A low phase lasting N cycles is committed as width N when the input rises. It updates `min_low` and `max_low` in the same way.
- R5: After reset or clear, the phase already in progress is not committed. Statistics start from the first phase that begins with a detected edge.
- R6: The phase counter saturates at 2^CNT_W-1 and does not wrap. A longer phase commits that ceiling value.
- R7: `bounce_flag` sets when a committed width is at most BOUNCE_MAX (default 2). It then stays set until a clear.
- R8: `dropout_flag` sets when a committed width exceeds DROP_MIN (default 10). It then stays set until a clear.
- R9: When `clr_stats` is high at a rising edge, the outputs return to their reset values at that edge, and R5 applies afresh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_stats | input | 1 | Clears statistics and flags, then re-arms |
| strobe_in | input | 1 | Raw asynchronous strobe under observation |
| min_high | output | CNT_W | Shortest committed high phase |
| max_high | output | CNT_W | Longest committed high phase |
| min_low | output | CNT_W | Shortest committed low phase |
| max_low | output | CNT_W | Longest committed low phase |
| bounce_flag | output | 1 | Sticky: a phase at or below BOUNCE_MAX was seen |
| dropout_flag | output | 1 | Sticky: a phase above DROP_MIN was seen |

## Verification
A phase width reaches the outputs three rising edges after the first sample of the edge that ends it. A clear shows on the outputs after a single edge. The bench drives the input at falling edges. After each burst it holds the level for four cycles before comparing, so every committed phase has settled and the unfinished last phase cannot yet be counted. One directed case samples after two edges and again after three, to pin the exact latency. The clear check samples one edge after the strobe.

// File: rtl/pwstat_pkg.sv
package pwstat_pkg;

    // Tracking states of the phase state machine
    typedef enum logic [2:0] {
        ST_ARM       = 3'd0,  // one cycle to read the current level after reset/clear
        ST_SKIP_HIGH = 3'd1,  // discarding a partial high phase
        ST_SKIP_LOW  = 3'd2,  // discarding a partial low phase
        ST_MEAS_HIGH = 3'd3,  // counting a high phase
        ST_MEAS_LOW  = 3'd4   // counting a low phase
    } phase_state_e;

    localparam int PH_HIGH = 0;
    localparam int PH_LOW  = 1;
    localparam int PH_NUM  = 2;

endpackage

// File: rtl/pwstat_sync.sv
module pwstat_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pwstat_phase_fsm.sv
module pwstat_phase_fsm
    import pwstat_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             lvl,
    output logic             commit_high,
    output logic             commit_low,
    output logic [CNT_W-1:0] width
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

    phase_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cnt_sat;

    assign cnt_sat = (cnt_q == CNT_TOP) ? CNT_TOP : cnt_q + CNT_ONE;

    // Next-state and counter update
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_ARM: begin
                state_d = lvl ? ST_SKIP_HIGH : ST_SKIP_LOW;
            end
            ST_SKIP_HIGH: begin
                if (!lvl) begin
                    state_d = ST_MEAS_LOW;
                    cnt_d   = CNT_ONE;
                end
            end
            ST_SKIP_LOW: begin
                if (lvl) begin
                    state_d = ST_MEAS_HIGH;
                    cnt_d   = CNT_ONE;
                end
            end
            ST_MEAS_HIGH: begin
                if (lvl) begin
                    cnt_d = cnt_sat;
                end else begin
                    state_d = ST_MEAS_LOW;
                    cnt_d   = CNT_ONE;
                end
            end
            ST_MEAS_LOW: begin
                if (!lvl) begin
                    cnt_d = cnt_sat;
                end else begin
                    state_d = ST_MEAS_HIGH;
                    cnt_d   = CNT_ONE;
                end
            end
            default: begin
                state_d = ST_ARM;
                cnt_d   = '0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARM;
            cnt_q   <= '0;
        end else if (clr) begin
            state_q <= ST_ARM;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs: a phase completes when the level leaves it
    always_comb begin
        commit_high = 1'b0;
        commit_low  = 1'b0;
        unique case (state_q)
            ST_MEAS_HIGH: commit_high = !lvl && !clr;
            ST_MEAS_LOW:  commit_low  = lvl && !clr;
            default: begin
                commit_high = 1'b0;
                commit_low  = 1'b0;
            end
        endcase
    end

    assign width = cnt_q;
endmodule

// File: rtl/pwstat_extreme.sv
module pwstat_extreme #(
    parameter int CNT_W      = 8,
    parameter int BOUNCE_MAX = 2,
    parameter int DROP_MIN   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             commit,
    input  logic [CNT_W-1:0] width,
    output logic [CNT_W-1:0] min_o,
    output logic [CNT_W-1:0] max_o,
    output logic             short_hit,
    output logic             long_hit
);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(BOUNCE_MAX);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(DROP_MIN);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            min_o <= '1;
            max_o <= '0;
        end else if (clr) begin
            min_o <= '1;
            max_o <= '0;
        end else if (commit) begin
            if (width < min_o) min_o <= width;
            if (width > max_o) max_o <= width;
        end
    end

    assign short_hit = commit && (width <= SHORT_LIM);
    assign long_hit  = commit && (width > LONG_LIM);
endmodule

// File: rtl/pwstat_monitor.sv
module pwstat_monitor
    import pwstat_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BOUNCE_MAX  = 2,
    parameter int DROP_MIN    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_stats,
    input  logic             strobe_in,
    output logic [CNT_W-1:0] min_high,
    output logic [CNT_W-1:0] max_high,
    output logic [CNT_W-1:0] min_low,
    output logic [CNT_W-1:0] max_low,
    output logic             bounce_flag,
    output logic             dropout_flag
);
    logic             lvl;
    logic             commit_high, commit_low;
    logic [CNT_W-1:0] width;
    logic [PH_NUM-1:0] commit_vec, short_vec, long_vec;
    logic [CNT_W-1:0] min_arr [PH_NUM];
    logic [CNT_W-1:0] max_arr [PH_NUM];
    logic             bounce_q, dropout_q;

    pwstat_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (strobe_in),
        .dout (lvl)
    );

    pwstat_phase_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (clr_stats),
        .lvl        (lvl),
        .commit_high(commit_high),
        .commit_low (commit_low),
        .width      (width)
    );

    assign commit_vec[PH_HIGH] = commit_high;
    assign commit_vec[PH_LOW]  = commit_low;

    generate
        for (genvar g = 0; g < PH_NUM; g++) begin : g_phase
            pwstat_extreme #(
                .CNT_W     (CNT_W),
                .BOUNCE_MAX(BOUNCE_MAX),
                .DROP_MIN  (DROP_MIN)
            ) u_ext (
                .clk      (clk),
                .rst_n    (rst_n),
                .clr      (clr_stats),
                .commit   (commit_vec[g]),
                .width    (width),
                .min_o    (min_arr[g]),
                .max_o    (max_arr[g]),
                .short_hit(short_vec[g]),
                .long_hit (long_vec[g])
            );
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bounce_q  <= 1'b0;
            dropout_q <= 1'b0;
        end else if (clr_stats) begin
            bounce_q  <= 1'b0;
            dropout_q <= 1'b0;
        end else begin
            bounce_q  <= bounce_q  | (|short_vec);
            dropout_q <= dropout_q | (|long_vec);
        end
    end

    assign min_high     = min_arr[PH_HIGH];
    assign max_high     = max_arr[PH_HIGH];
    assign min_low      = min_arr[PH_LOW];
    assign max_low      = max_arr[PH_LOW];
    assign bounce_flag  = bounce_q;
    assign dropout_flag = dropout_q;
endmodule

// File: rtl/pwstat_monitor_chk.sv
module pwstat_monitor_chk #(
    parameter int CNT_W      = 8,
    parameter int BOUNCE_MAX = 2,
    parameter int DROP_MIN   = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clr_stats,
    input logic [CNT_W-1:0] min_high,
    input logic [CNT_W-1:0] max_high,
    input logic [CNT_W-1:0] min_low,
    input logic [CNT_W-1:0] max_low,
    input logic             bounce_flag,
    input logic             dropout_flag
);
    localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(BOUNCE_MAX);
    localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(DROP_MIN);

    AST_HIGH_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (max_high != '0) |-> (min_high <= max_high)); // R3
    AST_LOW_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
        (max_low != '0) |-> (min_low <= max_low)); // R4
    AST_MIN_HIGH_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_stats |=> (min_high <= $past(min_high))); // R3
    AST_MAX_LOW_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_stats |=> (max_low >= $past(max_low))); // R4
    AST_BOUNCE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (bounce_flag && !clr_stats) |=> bounce_flag); // R7
    AST_BOUNCE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bounce_flag) |-> (min_high <= SHORT_LIM || min_low <= SHORT_LIM)); // R7
    AST_DROPOUT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (dropout_flag && !clr_stats) |=> dropout_flag); // R8
    AST_DROPOUT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dropout_flag) |-> (max_high > LONG_LIM || max_low > LONG_LIM)); // R8
    AST_CLEAR_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stats |=> (min_high == '1 && min_low == '1 && max_high == '0 &&
                       max_low == '0 && !bounce_flag && !dropout_flag)); // R9
endmodule

bind pwstat_monitor pwstat_monitor_chk #(
    .CNT_W     (CNT_W),
    .BOUNCE_MAX(BOUNCE_MAX),
    .DROP_MIN  (DROP_MIN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_stats   (clr_stats),
    .min_high    (min_high),
    .max_high    (max_high),
    .min_low     (min_low),
    .max_low     (max_low),
    .bounce_flag (bounce_flag),
    .dropout_flag(dropout_flag)
);

// File: tb/pwstat_monitor_tb.sv
module pwstat_monitor_tb;
    localparam int CNT_W = 8;
    localparam int TOP   = 255;
    localparam int BMAX  = 2;
    localparam int DMIN  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_stats = 1'b0;
    logic strobe_in = 1'b0;
    logic [CNT_W-1:0] min_high, max_high, min_low, max_low;
    logic bounce_flag, dropout_flag;

    always #4 clk = ~clk;

    pwstat_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .clr_stats(clr_stats), .strobe_in(strobe_in),
        .min_high(min_high), .max_high(max_high), .min_low(min_low), .max_low(max_low),
        .bounce_flag(bounce_flag), .dropout_flag(dropout_flag)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    // Bench model: index 0 = high phase, 1 = low phase
    int  exp_min [2];
    int  exp_max [2];
    bit  exp_bn, exp_dr;
    bit  m_lvl;
    int  m_w;
    bit  m_skip;

    function automatic void model_reset();
        exp_min[0] = TOP; exp_min[1] = TOP;
        exp_max[0] = 0;   exp_max[1] = 0;
        exp_bn = 0; exp_dr = 0;
        m_skip = 1;
    endfunction

    function automatic void model_commit(bit level, int w);
        int idx = level ? 0 : 1;
        if (w < exp_min[idx]) exp_min[idx] = w;
        if (w > exp_max[idx]) exp_max[idx] = w;
        if (w <= BMAX) exp_bn = 1;
        if (w > DMIN)  exp_dr = 1;
    endfunction

    task automatic cmp(input string name, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", name, act, exp);
        end
    endtask

    task automatic cmp_all(input string tag);
        cmp({tag, " min_high"}, int'(min_high), exp_min[0]);
        cmp({tag, " max_high"}, int'(max_high), exp_max[0]);
        cmp({tag, " min_low"},  int'(min_low),  exp_min[1]);
        cmp({tag, " max_low"},  int'(max_low),  exp_max[1]);
        cmp({tag, " bounce"},   int'(bounce_flag),  int'(exp_bn));
        cmp({tag, " dropout"},  int'(dropout_flag), int'(exp_dr));
    endtask

    // One input cycle, driven at the falling edge
    task automatic step(input bit lv);
        @(negedge clk);
        clr_stats = 1'b0;
        if (lv != m_lvl) begin
            if (!m_skip) model_commit(m_lvl, m_w);
            m_skip = 0;
            m_lvl  = lv;
            m_w    = 1;
        end else if (m_w < TOP) begin
            m_w++;
        end
        strobe_in = lv;
    endtask

    task automatic phase(input bit lv, input int w);
        for (int i = 0; i < w; i++) step(lv);
    endtask

    task automatic hold_check(input string tag);
        for (int i = 0; i < 4; i++) step(m_lvl);
        cmp_all(tag);
    endtask

    task automatic do_clear();
        clr_stats = 1'b1;
        step(m_lvl);
        model_reset();
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired act=0 exp=1");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int snap_max_high;
        void'($urandom(32'd20240611));
        m_lvl = 0; m_w = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_all("R1 reset");

        // R5: long initial low must be discarded; then normal phases (R3, R4)
        phase(0, 20);
        phase(1, 6);
        phase(0, 7);
        phase(1, 7);
        phase(0, 6);
        hold_check("R5 R3 R4 nominal");

        // R2: exact latency of a committed phase
        phase(1, 8);
        snap_max_high = exp_max[0];
        step(0);
        step(0);
        step(0);
        cmp("R2 not yet at edge+2", int'(max_high), snap_max_high);
        step(0);
        cmp("R2 visible at edge+3", int'(max_high), 8);
        hold_check("R2 settle");

        // R7: single-cycle high glitch
        phase(1, 1);
        phase(0, 6);
        hold_check("R7 bounce");

        // R8: long low phase
        phase(1, 6);
        phase(0, 15);
        phase(1, 6);
        hold_check("R8 dropout");

        // R7 R8 sticky across normal traffic
        phase(0, 7);
        phase(1, 7);
        phase(0, 6);
        hold_check("R7 R8 sticky");

        // R9: clear restores reset values one edge later
        do_clear();
        cmp_all("R9 clear");

        // R5 after clear: partial phase discarded
        phase(m_lvl, 12);
        phase(!m_lvl, 6);
        phase(!m_lvl, 7);
        hold_check("R5 after clear");

        // R6: saturation
        do_clear();
        phase(0, 5);
        phase(1, 300);
        phase(0, 6);
        phase(1, 7);
        hold_check("R6 saturate");

        // Random traffic
        for (int b = 0; b < 60; b++) begin
            if (b % 12 == 0) begin
                do_clear();
                cmp_all("R9 random clear");
            end
            for (int p = 0; p < 6; p++) begin
                int r = int'($urandom % 16);
                int w;
                if (r < 2)      w = 1 + int'($urandom % 2);
                else if (r < 4) w = 11 + int'($urandom % 10);
                else            w = 6 + int'($urandom % 2);
                phase(!m_lvl, w);
            end
            hold_check("R3 R4 R7 R8 random");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule